// File: doc/BRIEF.md
# PHY Start-up Timing Sequencer

This block drives the power-on and re-initialization handshake of a storage-card interface PHY. Software programs a 32-bit control word that holds two mode bits and four 4-bit phase durations. Setting the top bit of that word starts a timed run. During the run the block raises a synchronization-enable strobe, leaves a programmable idle gap, raises a synchronization-reset strobe, and then waits out a settling period followed by a fixed 8-cycle tail. When the run ends the top bit clears itself. The top bit therefore reads as one for exactly as long as the run lasts, and a poller can treat a remaining one as "still initializing".

The run has to be started again whenever the card clock frequency changes, whenever that clock is gated off and back on, and whenever the PHY timing or function settings are rewritten. The block does not decide when this is needed. It only runs the run and reports the end with `busy` falling and a one-cycle `done` pulse.

Top module: `phy_init_seq`

## Requirements
- R1: After a synchronous active-low reset, `rd_data` reads 0 and `sync_en`, `sync_rst`, `busy` and `done` are all low.
- R2: The control word has these fields: bit 31 is the start/in-progress bit, bit 29 is the slow-mode bit, bit 28 is the SDIO-mode bit, [15:12] is the settle count, [11:8] is the sync-enable length, [7:4] is the gap length and [3:0] is the sync-reset length. All other bits read zero. A write with bit 31 low stores the fields and starts nothing.
- R3: A write with bit 31 high while idle starts a run. From the next cycle until the run ends, bit 31 of `rd_data` and `busy` are both high.
- R4: `sync_en` is high for exactly the sync-enable count of cycles, starting in the first cycle after the start write.
- R5: After the gap count of low cycles, `sync_rst` is high for exactly the sync-reset count of cycles.
- R6: A run lasts exactly (enable + gap + reset + settle + 8) cycles.
- R7: A phase whose count is zero is skipped. With all counts zero the run is the 8-cycle tail alone, and no strobe is raised.
- R8: `done` is high for exactly one cycle, and that cycle is the first one in which bit 31 reads zero.
- R9: A write with bit 31 high during a run neither restarts the run nor lengthens it.
- R10: Count fields written during a run read back at once. The run in progress keeps the counts it latched at its start, and the new counts apply to the next run.
- R11: The mode bits written with the start write are kept through the run and after it.
- R12: `sync_en` and `sync_rst` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word write data |
| rd_data | output | 32 | Control word readback; bit 31 shows that a run is in progress |
| sync_en | output | 1 | Synchronization-enable strobe to the PHY |
| sync_rst | output | 1 | Synchronization-reset strobe to the PHY |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse when a run ends |

## Verification
The hardest case to reach from the ports is a control write that lands in the middle of a run. That write carries both a new start request and new counts. The run in progress must ignore the start request and keep its latched lengths, yet the new counts must show up in the readback at once. The bench reaches this case by issuing a second write at a chosen cycle offset inside a known run. It then checks the whole strobe profile of that run against the old counts, and after `done` it checks the readback against the new ones. Zero counts in every single position and in all positions together exercise the phase-skipping path.

// File: rtl/pis_pkg.sv
package pis_pkg;
    // Phase order is behaviour: strobes follow this sequence.
    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_SEN  = 3'd1,
        PH_GAP  = 3'd2,
        PH_SRST = 3'd3,
        PH_WAIT = 3'd4,
        PH_TAIL = 3'd5
    } phase_e;

    localparam int NUM_TIMED = 4;  // programmable phases before the tail
endpackage

// File: rtl/pis_phase_sel.sv
// Picks the next phase with a nonzero length after the current one.
module pis_phase_sel
    import pis_pkg::*;
#(
    parameter int DUR_W       = 4,
    parameter int TAIL_CYCLES = 8,
    parameter int CNT_W       = 5
) (
    input  phase_e                       cur,
    input  logic [NUM_TIMED*DUR_W-1:0]   lens,   // [0]=enable [1]=gap [2]=reset [3]=settle
    output phase_e                       nxt,
    output logic [CNT_W-1:0]             nxt_len
);
    always_comb begin
        nxt     = PH_TAIL;
        nxt_len = CNT_W'(TAIL_CYCLES);
        // descending scan so the earliest eligible phase wins
        for (int i = NUM_TIMED - 1; i >= 0; i--) begin
            if ((i + 1) > int'(cur) && lens[i*DUR_W +: DUR_W] != '0) begin
                nxt     = phase_e'(3'(i + 1));
                nxt_len = CNT_W'(lens[i*DUR_W +: DUR_W]);
            end
        end
    end
endmodule

// File: rtl/pis_seq.sv
// Phase sequencer: latches lengths at start, walks phases, pulses done.
module pis_seq
    import pis_pkg::*;
#(
    parameter int DUR_W       = 4,
    parameter int TAIL_CYCLES = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic [NUM_TIMED*DUR_W-1:0] lens_in,
    output phase_e                     phase,
    output logic                       done
);
    localparam int TAIL_W = $clog2(TAIL_CYCLES + 1);
    localparam int CNT_W  = (DUR_W > TAIL_W) ? DUR_W : TAIL_W;

    typedef struct packed {
        phase_e                     phase;
        logic [CNT_W-1:0]           cnt;
        logic [NUM_TIMED*DUR_W-1:0] snap;
        logic                       done;
    } seq_t;

    seq_t s_q, s_d;

    logic [NUM_TIMED*DUR_W-1:0] sel_lens;
    phase_e                     sel_nxt;
    logic [CNT_W-1:0]           sel_len;

    assign sel_lens = (s_q.phase == PH_IDLE) ? lens_in : s_q.snap;

    pis_phase_sel #(
        .DUR_W(DUR_W), .TAIL_CYCLES(TAIL_CYCLES), .CNT_W(CNT_W)
    ) u_sel (
        .cur(s_q.phase), .lens(sel_lens), .nxt(sel_nxt), .nxt_len(sel_len)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (s_q.phase == PH_IDLE) begin
            if (start) begin
                s_d.snap  = lens_in;
                s_d.phase = sel_nxt;
                s_d.cnt   = sel_len - 1'b1;
            end
        end else if (s_q.cnt == '0) begin
            if (s_q.phase == PH_TAIL) begin
                s_d.phase = PH_IDLE;
                s_d.done  = 1'b1;
            end else begin
                s_d.phase = sel_nxt;
                s_d.cnt   = sel_len - 1'b1;
            end
        end else begin
            s_d.cnt = s_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign phase = s_q.phase;
    assign done  = s_q.done;

    // Latched lengths hold still for the whole run.
    AST_SNAP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase != PH_IDLE && $past(s_q.phase) != PH_IDLE) |-> $stable(s_q.snap)); // R10
    // Once in the tail the only way out is back to idle.
    AST_TAIL_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase == PH_TAIL) |=> (s_q.phase == PH_TAIL || s_q.phase == PH_IDLE)); // R6
endmodule

// File: rtl/phy_init_seq.sv
module phy_init_seq
    import pis_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int DUR_W       = 4,
    parameter int TAIL_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              sync_en,
    output logic              sync_rst,
    output logic              busy,
    output logic              done
);
    localparam int FLD_W    = NUM_TIMED * DUR_W;
    localparam int START_B  = DATA_W - 1;
    localparam int SLOW_B   = DATA_W - 3;
    localparam int SDIO_B   = DATA_W - 4;
    // register field slots: reset length lowest, then gap, enable, settle
    localparam int RST_F    = 0;
    localparam int GAP_F    = 1;
    localparam int EN_F     = 2;
    localparam int WAIT_F   = 3;

    typedef struct packed {
        logic             slow;
        logic             sdio;
        logic [FLD_W-1:0] dur;
    } cfg_t;

    cfg_t   c_q, c_d;
    phase_e phase;
    logic   start;
    logic [FLD_W-1:0] lens_in;

    assign busy  = (phase != PH_IDLE);
    assign start = wr_en && wr_data[START_B] && !busy;

    // reorder register slots into sequencer phase order
    assign lens_in = { wr_data[WAIT_F*DUR_W +: DUR_W],
                       wr_data[RST_F*DUR_W  +: DUR_W],
                       wr_data[GAP_F*DUR_W  +: DUR_W],
                       wr_data[EN_F*DUR_W   +: DUR_W] };

    always_comb begin
        c_d = c_q;
        if (wr_en) begin
            c_d.slow = wr_data[SLOW_B];
            c_d.sdio = wr_data[SDIO_B];
            c_d.dur  = wr_data[FLD_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    pis_seq #(.DUR_W(DUR_W), .TAIL_CYCLES(TAIL_CYCLES)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .lens_in(lens_in),
        .phase(phase), .done(done)
    );

    always_comb begin
        rd_data          = '0;
        rd_data[START_B] = busy;
        rd_data[SLOW_B]  = c_q.slow;
        rd_data[SDIO_B]  = c_q.sdio;
        rd_data[FLD_W-1:0] = c_q.dur;
    end

    assign sync_en  = (phase == PH_SEN);
    assign sync_rst = (phase == PH_SRST);

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(sync_en && sync_rst)); // R12
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_DONE_ON_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done); // R8
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !rd_data[START_B]); // R8
    AST_END_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(!sync_en && !sync_rst)); // R6
    AST_START_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[START_B] && !busy) |=> busy); // R3
endmodule

// File: tb/tb_phy_init_seq.sv
module tb_phy_init_seq;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [31:0] wr_data;
    logic [31:0] rd_data;
    logic        sync_en, sync_rst, busy, done;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;  // 200 MHz

    phy_init_seq dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .sync_en(sync_en), .sync_rst(sync_rst),
        .busy(busy), .done(done)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] word(input bit st, input bit slow, input bit sdio,
                                         input int en, input int gap, input int rs, input int wt);
        return {st, 1'b0, slow, sdio, 12'h0, 4'(wt), 4'(en), 4'(gap), 4'(rs)};
    endfunction

    // Starts a run and compares every cycle's outputs with the profile
    // expected from the counts. Optional second write at offset mid_at.
    task automatic run_seq(input string tag, input int en, input int gap, input int rs,
                           input int wt, input bit slow, input bit sdio,
                           input int mid_at, input logic [31:0] mid_data);
        int total = en + gap + rs + wt + 8;
        int bad_en = 0, bad_rst = 0, bad_busy = 0, bad_done = 0, bad_both = 0;
        int k = 0;
        @(negedge clk);
        wr_en = 1'b1; wr_data = word(1'b1, slow, sdio, en, gap, rs, wt);
        @(negedge clk);
        wr_en = 1'b0;
        while (k <= total + 2) begin
            bit e_en   = (k < en);
            bit e_rst  = (k >= en + gap) && (k < en + gap + rs);
            bit e_busy = (k < total);
            bit e_done = (k == total);
            if (sync_en  !== e_en)   bad_en++;
            if (sync_rst !== e_rst)  bad_rst++;
            if (busy !== e_busy || rd_data[31] !== e_busy) bad_busy++;
            if (done !== e_done)     bad_done++;
            if (sync_en && sync_rst) bad_both++;
            if (k == mid_at) begin
                wr_en = 1'b1; wr_data = mid_data;
            end else begin
                wr_en = 1'b0;
            end
            k++;
            @(negedge clk);
        end
        wr_en = 1'b0;
        check({"R4 ", tag}, "sync_en profile mismatches", bad_en, 0);
        check({"R5 ", tag}, "sync_rst profile mismatches", bad_rst, 0);
        check({"R6/R3 ", tag}, "busy/bit31 profile mismatches", bad_busy, 0);
        check({"R8 ", tag}, "done profile mismatches", bad_done, 0);
        check({"R12 ", tag}, "overlapping strobes", bad_both, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_data = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", "rd_data", rd_data, 32'h0);
        check("R1", "outputs", {28'h0, sync_en, sync_rst, busy, done}, 32'h0);
        rst_n = 1'b1;

        // R2 field store without start
        @(negedge clk); wr_en = 1'b1; wr_data = 32'h7FFF_FFFF;
        @(negedge clk); wr_en = 1'b0;
        check("R2", "readback", rd_data, 32'h3000_FFFF);
        check("R2", "no run started", {31'h0, busy}, 32'h0);
        repeat (3) @(negedge clk);
        check("R2", "still idle", {30'h0, sync_en, busy}, 32'h0);

        // main runs, distinct patterns
        run_seq("basic", 2, 3, 4, 5, 1'b0, 1'b0, -1, '0);
        run_seq("max", 15, 15, 15, 15, 1'b1, 1'b0, -1, '0);
        check("R11", "mode bits after run", {30'h0, rd_data[29:28]}, 32'h2);
        run_seq("ones", 1, 1, 1, 1, 1'b0, 1'b1, -1, '0);
        check("R11", "sdio bit after run", {30'h0, rd_data[29:28]}, 32'h1);
        // R7 zero skipping
        run_seq("R7 allzero", 0, 0, 0, 0, 1'b0, 0, -1, '0);
        run_seq("R7 noen", 0, 2, 3, 1, 1'b0, 0, -1, '0);
        run_seq("R7 nogap", 3, 0, 2, 0, 1'b0, 0, -1, '0);
        run_seq("R7 norst", 2, 2, 0, 2, 1'b0, 0, -1, '0);
        // R9/R10 mid-run write: start bit ignored, new counts only stored
        run_seq("R9 midwrite", 2, 2, 2, 2, 1'b1, 1'b1, 3, word(1'b1, 1'b0, 1'b0, 9, 9, 9, 9));
        check("R10", "new counts read back", rd_data, 32'h0000_9999);
        // R10 next run uses the newly written counts
        run_seq("R10 next", 9, 9, 9, 9, 1'b0, 1'b0, -1, '0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule